// File: doc/BRIEF.md
# Reference Phase Lock Timeout Alarm

This block watches the reference input that the main clock path currently follows and checks that phase lock arrives within a programmable number of seconds. Time is measured by a one-cycle strobe that pulses once per second. The timeout is the product of a 6-bit seconds value and a 2-bit multiplier. If lock is still missing when the timeout runs out, the block sets a sticky alarm bit for that input. It also drives a matching disqualify bit, so the reference selector stops offering that input for main-path locking.

A mode input decides how alarms go away. In software-clear mode, writing a 1 to an alarm bit clears it. In expiry mode, each alarm clears itself one timeout period after it was raised. Each input has its own expiry counter, so several alarms can run down at the same time.

Top module: `pl_timeout_alarm`

## Requirements
- R1: The timeout limit is `tmo_value * tmo_mult`. The alarm bit of the selected input is set at the clock edge that samples the limit-th `sec_tick` pulse, counted while `main_locked` stays low and `sel_idx` stays unchanged. If the input stays unlocked, the count restarts and the alarm is raised again every limit ticks.
- R2: The wait count restarts from zero in any cycle where `main_locked` is high or `sel_idx` differs from its value in the previous cycle. A tick in such a cycle is not counted.
- R3: Each input has its own alarm bit. A `sel_idx` value k in the range 0 to NUM_IN-1 selects input k, which maps to alarm bit k. Values of NUM_IN and above select no input, and no alarm is raised for them.
- R4: If the limit is zero (value or multiplier equal to 0), no alarm is ever raised.
- R5: With `clr_mode` = 0 (software clear), a cycle with `wr_en` high clears every alarm bit whose `wr_data` bit is 1. A 0 in `wr_data` leaves that bit unchanged. An alarm never clears by any other means in this mode.
- R6: With `clr_mode` = 1 (expiry), an alarm clears at the edge that samples the limit-th `sec_tick` after the edge that raised it. Writes have no effect in this mode.
- R7: Expiry counters are per input, so alarms raised at different times clear at different times.
- R8: If an alarm is raised and cleared (by write or by expiry) in the same cycle for the same input, the alarm ends up set, and its expiry count restarts.
- R9: `disq_mask` equals `alarm` in every cycle.
- R10: An active `rst_n` clears all alarms and all counters at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| sel_idx | input | IDX_W (4) | Index of the input followed by the main path |
| main_locked | input | 1 | Main path reports phase lock |
| tmo_value | input | TVAL_W (6) | Timeout seconds value |
| tmo_mult | input | MULT_W (2) | Timeout multiplier |
| clr_mode | input | 1 | 0 = software clear, 1 = expiry clear |
| wr_en | input | 1 | Alarm write strobe |
| wr_data | input | NUM_IN (14) | Write-one-to-clear mask |
| alarm | output | NUM_IN (14) | Sticky alarm bits per input |
| disq_mask | output | NUM_IN (14) | Per-input disqualify mask for the reference selector |

## Verification
The bench builds the block with its default parameters: fourteen inputs, a 6-bit value and a 2-bit multiplier. With these, the largest limit of 189 seconds and both zero-limit cases can be reached from the vector table. The 4-bit index also has the codes 14 and 15, which select no input, so the out-of-range path can be driven at the ports. Directed sequences then cover the following cases: a restart on lock, a restart on an index change, a raise and a write in the same cycle, and two expiry counters running at once.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned DEF_NUM_IN = 14;
  localparam int unsigned DEF_TVAL_W = 6;
  localparam int unsigned DEF_MULT_W = 2;

  typedef enum logic {
    CLR_BY_WRITE  = 1'b0,
    CLR_BY_EXPIRY = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/pla_lock_timer.sv
module pla_lock_timer #(
  parameter int unsigned NUM_IN = 14,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned LIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              main_locked,
  input  logic [LIM_W-1:0]  limit,
  output logic [NUM_IN-1:0] raise_vec
);
  logic [IDX_W-1:0] prev_q;
  logic [LIM_W-1:0] wait_q, wait_d;
  logic             wait_en;
  logic             moved, sel_ok, lim_on, reach, fire;

  always_comb begin
    moved   = (sel_idx != prev_q);
    sel_ok  = ({1'b0, sel_idx} < (IDX_W+1)'(NUM_IN));
    lim_on  = (limit != '0);
    reach   = (({1'b0, wait_q} + 1'b1) >= {1'b0, limit});
    wait_d  = wait_q;
    wait_en = 1'b0;
    fire    = 1'b0;
    if (main_locked || moved || !sel_ok || !lim_on) begin
      wait_d  = '0;
      wait_en = 1'b1;
    end else if (sec_tick) begin
      wait_en = 1'b1;
      if (reach) begin
        wait_d = '0;
        fire   = 1'b1;
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
    for (int i = 0; i < NUM_IN; i++) begin
      raise_vec[i] = fire && (sel_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      wait_q <= '0;
    end else begin
      prev_q <= sel_idx;
      if (wait_en) wait_q <= wait_d;
    end
  end

  AST_NO_RAISE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    main_locked |-> (raise_vec == '0)); // R2
endmodule

// File: rtl/pla_alarm_cell.sv
module pla_alarm_cell #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             auto_mode,
  input  logic [LIM_W-1:0] limit,
  input  logic             set_req,
  input  logic             clr_req,
  output logic             alarm
);
  logic             alm_q, alm_d;
  logic [LIM_W-1:0] exp_q, exp_d;
  logic             expire, wclr;

  always_comb begin
    expire = auto_mode && alm_q && sec_tick &&
             (({1'b0, exp_q} + 1'b1) >= {1'b0, limit});
    wclr   = !auto_mode && clr_req;
    alm_d  = set_req | (alm_q & ~(expire | wclr));
    exp_d  = exp_q;
    if (set_req || !auto_mode || !alm_q || expire) begin
      exp_d = '0;
    end else if (sec_tick) begin
      exp_d = exp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= 1'b0;
      exp_q <= '0;
    end else begin
      alm_q <= alm_d;
      exp_q <= exp_d;
    end
  end

  assign alarm = alm_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> alm_q); // R8
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && alm_q && !clr_req) |=> alm_q); // R5
  AST_EXPIRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(alm_q) && $past(auto_mode)) |-> $past(sec_tick)); // R6
  AST_WRITE_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(alm_q) && !$past(auto_mode)) |-> $past(clr_req)); // R5
endmodule

// File: rtl/pl_timeout_alarm.sv
module pl_timeout_alarm
  import pla_pkg::*;
#(
  parameter int unsigned NUM_IN = DEF_NUM_IN,
  parameter int unsigned TVAL_W = DEF_TVAL_W,
  parameter int unsigned MULT_W = DEF_MULT_W,
  parameter int unsigned IDX_W  = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              main_locked,
  input  logic [TVAL_W-1:0] tmo_value,
  input  logic [MULT_W-1:0] tmo_mult,
  input  logic              clr_mode,
  input  logic              wr_en,
  input  logic [NUM_IN-1:0] wr_data,
  output logic [NUM_IN-1:0] alarm,
  output logic [NUM_IN-1:0] disq_mask
);
  localparam int unsigned LIM_W = TVAL_W + MULT_W;

  logic              rst_s1_q, rst_s2_q;
  logic [LIM_W-1:0]  limit;
  logic [NUM_IN-1:0] raise_vec;
  logic [NUM_IN-1:0] clr_vec;
  logic              auto_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  always_comb begin
    limit     = LIM_W'(tmo_value) * LIM_W'(tmo_mult);
    auto_mode = (clr_mode_e'(clr_mode) == CLR_BY_EXPIRY);
    clr_vec   = wr_en ? wr_data : '0;
  end

  pla_lock_timer #(
    .NUM_IN (NUM_IN),
    .IDX_W  (IDX_W),
    .LIM_W  (LIM_W)
  ) timer_i (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .sec_tick    (sec_tick),
    .sel_idx     (sel_idx),
    .main_locked (main_locked),
    .limit       (limit),
    .raise_vec   (raise_vec)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_cell
    pla_alarm_cell #(
      .LIM_W (LIM_W)
    ) cell_i (
      .clk       (clk),
      .rst_n     (rst_s2_q),
      .sec_tick  (sec_tick),
      .auto_mode (auto_mode),
      .limit     (limit),
      .set_req   (raise_vec[g]),
      .clr_req   (clr_vec[g]),
      .alarm     (alarm[g])
    );
  end

  assign disq_mask = alarm;

  AST_ONE_RAISE: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $onehot0(raise_vec)); // R3
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (limit == '0) |-> (raise_vec == '0)); // R4
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_s2_q)
    ((alarm & ~$past(alarm)) != '0) |-> $past(sec_tick)); // R1
endmodule

// File: tb/pl_timeout_alarm_tb.sv
module pl_timeout_alarm_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 14;

  typedef struct packed {
    logic [5:0] tv;
    logic [1:0] ml;
    logic [7:0] nt;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{tv:6'd3,  ml:2'd1, nt:8'd2,   exp:1'b0},
    '{tv:6'd3,  ml:2'd1, nt:8'd3,   exp:1'b1},
    '{tv:6'd2,  ml:2'd2, nt:8'd3,   exp:1'b0},
    '{tv:6'd2,  ml:2'd2, nt:8'd4,   exp:1'b1},
    '{tv:6'd0,  ml:2'd3, nt:8'd10,  exp:1'b0},
    '{tv:6'd5,  ml:2'd0, nt:8'd10,  exp:1'b0},
    '{tv:6'd1,  ml:2'd1, nt:8'd1,   exp:1'b1},
    '{tv:6'd4,  ml:2'd3, nt:8'd11,  exp:1'b0},
    '{tv:6'd4,  ml:2'd3, nt:8'd12,  exp:1'b1},
    '{tv:6'd63, ml:2'd3, nt:8'd188, exp:1'b0},
    '{tv:6'd63, ml:2'd3, nt:8'd189, exp:1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sec_tick;
  logic [3:0]   sel_idx;
  logic         main_locked;
  logic [5:0]   tmo_value;
  logic [1:0]   tmo_mult;
  logic         clr_mode;
  logic         wr_en;
  logic [N-1:0] wr_data;
  logic [N-1:0] alarm;
  logic [N-1:0] disq_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pl_timeout_alarm dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .sel_idx     (sel_idx),
    .main_locked (main_locked),
    .tmo_value   (tmo_value),
    .tmo_mult    (tmo_mult),
    .clr_mode    (clr_mode),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .alarm       (alarm),
    .disq_mask   (disq_mask)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [N-1:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic chk(string req, logic [N-1:0] exp);
    checks++;
    if (alarm !== exp) begin
      errors++;
      $display("FAIL %s alarm actual=%h expected=%h", req, alarm, exp);
    end
    checks++;
    if (disq_mask !== exp) begin
      errors++;
      $display("FAIL R9 disq_mask actual=%h expected=%h", disq_mask, exp);
    end
  endtask

  task automatic clear_all();
    clr_mode = 1'b0;
    main_locked = 1'b1;
    cyc(1);
    wr({N{1'b1}});
    cyc(1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sec_tick = 1'b0;
    sel_idx = '0;
    main_locked = 1'b1;
    tmo_value = '0;
    tmo_mult = '0;
    clr_mode = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk("R10 reset", '0);

    // vector table: R1 limit product, R4 zero limit
    for (int i = 0; i < 11; i++) begin
      logic [N-1:0] e;
      clear_all();
      tmo_value = VEC[i].tv;
      tmo_mult = VEC[i].ml;
      sel_idx = 4'(i % N);
      cyc(1);
      main_locked = 1'b0;
      cyc(1);
      tick(int'(VEC[i].nt));
      e = '0;
      if (VEC[i].exp) e[i % N] = 1'b1;
      chk((VEC[i].tv == 0 || VEC[i].ml == 0) ? "R4 zero limit" : "R1 timeout", e);
    end

    // R2 lock restarts the count
    clear_all();
    tmo_value = 6'd3; tmo_mult = 2'd1; sel_idx = 4'd2;
    cyc(1);
    main_locked = 1'b0; cyc(1);
    tick(2);
    main_locked = 1'b1; cyc(1);
    main_locked = 1'b0; cyc(1);
    tick(2);
    chk("R2 lock restart", '0);
    tick(1);
    chk("R2 raise after restart", 14'h0004);

    // R2/R3 index change restarts and targets the new bit
    clear_all();
    main_locked = 1'b0; sel_idx = 4'd4; cyc(1);
    tick(2);
    sel_idx = 4'd5; cyc(1);
    tick(2);
    chk("R2 index change restart", '0);
    tick(1);
    chk("R3 per-input bit", 14'h0020);

    // R5 write zero no effect, write one clears
    main_locked = 1'b1; cyc(1);
    wr(14'h3FDF);
    cyc(1);
    chk("R5 write zero ignored", 14'h0020);
    wr(14'h0020);
    cyc(1);
    chk("R5 write one clears", '0);

    // R3 out-of-range index
    main_locked = 1'b0; sel_idx = 4'd15; cyc(1);
    tick(5);
    chk("R3 out-of-range index", '0);

    // R8 raise and write-clear in the same cycle
    clear_all();
    tmo_value = 6'd2; tmo_mult = 2'd1; sel_idx = 4'd7; cyc(1);
    main_locked = 1'b0; cyc(1);
    tick(2);
    chk("R1 raise bit7", 14'h0080);
    tick(1);
    sec_tick = 1'b1; wr_en = 1'b1; wr_data = {N{1'b1}};
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    cyc(1);
    chk("R8 set wins over write", 14'h0080);

    // R6/R7 expiry mode with two counters
    clear_all();
    clr_mode = 1'b1;
    tmo_value = 6'd1; tmo_mult = 2'd2; sel_idx = 4'd8; cyc(1);
    main_locked = 1'b0; cyc(1);
    tick(2);
    chk("R1 raise bit8 via multiplier", 14'h0100);
    sel_idx = 4'd9; cyc(1);
    wr({N{1'b1}});
    cyc(1);
    chk("R6 write ignored in expiry mode", 14'h0100);
    tick(1);
    chk("R6 not yet expired", 14'h0100);
    tick(1);
    chk("R7 independent expiry", 14'h0200);
    main_locked = 1'b1; cyc(1);
    tick(1);
    chk("R6 one tick after raise", 14'h0200);
    tick(1);
    chk("R6 expired", '0);

    // R10 reset while an alarm is set
    clr_mode = 1'b0; sel_idx = 4'd0; cyc(1);
    main_locked = 1'b0; cyc(1);
    tick(2);
    chk("R1 raise bit0", 14'h0001);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset", '0);
    cyc(2);
    rst_n = 1'b1;
    main_locked = 1'b1;
    cyc(4);
    chk("R10 after release", '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule